// File: doc/BRIEF.md
# Vector Extended-Dividend Word Divider

This unit divides four 32-bit word lanes of a 128-bit vector in parallel. In each lane, the operand A is placed in the upper half of a 64-bit dividend and zeros fill the lower half, so the dividend equals A times 2^32. That dividend is divided by the operand B of the same lane, and the lane result is the low 32 bits of the quotient. A decoder checks the instruction opcode fields to choose between a signed form and an unsigned form. Opcodes that match neither form are refused.

The execution pipeline delivers the primary and extended opcode fields, the two source vectors and a one-cycle start strobe. The register-number fields are decoded elsewhere and do not reach this unit. The unit is iterative. It works out one quotient bit per cycle in every lane, raises busy while it works, and pulses done when the result vector is valid. The result holds its value until the next operation completes. A zero divisor never stalls the unit. The signed most-negative-by-minus-one case produces a defined value and raises no fault.

Top module: `vxdiv_unit`

## Requirements
- R1: A start pulse taken while busy is low, with primOp equal to 6'b000100, starts a signed divide when extOp is 11'b01110001011 and an unsigned divide when extOp is 11'b01010001011. Busy goes high in the next cycle.
- R2: A start pulse taken while busy is low with any other primOp or extOp value raises illegal for exactly the next cycle. It does not raise busy or done and leaves result unchanged.
- R3: In unsigned mode, each lane result is the low 32 bits of floor((A * 2^32) / B), with A and B taken as unsigned.
- R4: In signed mode, A and B are read as two's-complement values. The quotient of (A * 2^32) / B is truncated toward zero, and the lane result is the low 32 bits of its two's-complement form.
- R5: Lane i takes bits [32i+31:32i] of srcA and srcB and drives the same bits of result. Each lane's value depends only on its own operands.
- R6: A lane whose B is zero returns 32'h0. The other lanes return their normal results, and the operation completes with normal timing.
- R7: In signed mode, A = 32'h80000000 with B = 32'hFFFFFFFF returns 32'h0, which is the low half of 2^63, and the operation completes normally. A quotient too wide for 32 bits also yields its low 32 bits.
- R8: Done is high for exactly one cycle, 64 cycles after the clock edge that accepted the start. Busy is high from the cycle after acceptance until done rises, and it is low while done is high.
- R9: A start pulse taken while busy is high is ignored. It does not change the running operation, its result or its timing, and it does not raise illegal.
- R10: After reset, busy, done and illegal are low and result is zero. Result changes only in a cycle in which done is high, and it holds its value after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a divide |
| primOp | input | 6 | Primary opcode field of the instruction |
| extOp | input | 11 | Extended opcode field of the instruction |
| srcA | input | 128 | Dividend-high vector, four 32-bit lanes |
| srcB | input | 128 | Divisor vector, four 32-bit lanes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| illegal | output | 1 | One-cycle pulse, opcode refused |
| result | output | 128 | Quotient vector, four 32-bit lanes |

## Verification
A quotient is due exactly 64 cycles after the edge that samples start, and an illegal pulse is due one cycle after that edge. The bench drives start on a falling edge. It then counts rising edges and samples on each following falling edge, so it measures the latency instead of assuming it. It reads the result vector in the first cycle where done is high and again several cycles later to confirm the hold. For refused opcodes and for a start taken while busy, the bench checks the illegal, busy and done flags in the cycles right after the stimulus. It also compares the result vector against its value from before the stimulus.

// File: rtl/vxdiv_pkg.sv
package vxdiv_pkg;

  // Opcode encodings decoded by the control
  localparam logic [5:0]  PRIMARY_OP   = 6'b000100;
  localparam logic [10:0] XOP_SIGNED   = 11'b01110001011;
  localparam logic [10:0] XOP_UNSIGNED = 11'b01010001011;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands, initialise lane state
    logic step;      // produce one quotient bit
    logic finish;    // last step: register lane results
    logic signedOp;  // mode for the operands being loaded
  } dpCtrl_t;

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

endpackage

// File: rtl/vxdiv_ctrl.sv
module vxdiv_ctrl
  import vxdiv_pkg::*;
#(
  parameter int ITER = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [5:0]  primOp,
  input  logic [10:0] extOp,
  output dpCtrl_t     dpCtrl,
  output logic        busy,
  output logic        done,
  output logic        illegal
);

  localparam int CNT_W = $clog2(ITER);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITER - 1);

  ctrlState_t state;
  logic [CNT_W-1:0] iterCnt;

  logic isSigned, isUnsigned, legalOp;
  logic accept, reject, lastIter;

  always_comb begin
    isSigned   = (primOp == PRIMARY_OP) && (extOp == XOP_SIGNED);
    isUnsigned = (primOp == PRIMARY_OP) && (extOp == XOP_UNSIGNED);
    legalOp    = isSigned || isUnsigned;
    accept     = (state == ST_IDLE) && start && legalOp;
    reject     = (state == ST_IDLE) && start && !legalOp;
    lastIter   = (state == ST_RUN) && (iterCnt == LAST_CNT);
  end

  always_comb begin
    dpCtrl.load     = accept;
    dpCtrl.step     = (state == ST_RUN);
    dpCtrl.finish   = lastIter;
    dpCtrl.signedOp = isSigned;
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= lastIter;
      illegal <= reject;
      if (accept) begin
        state   <= ST_RUN;
        iterCnt <= '0;
      end else if (state == ST_RUN) begin
        if (lastIter) begin
          state <= ST_IDLE;
        end else begin
          iterCnt <= iterCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vxdiv_lane.sv
module vxdiv_lane
  import vxdiv_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [LANE_W-1:0] opA,
  input  logic [LANE_W-1:0] opB,
  output logic [LANE_W-1:0] res
);

  localparam int DIVD_W = 2 * LANE_W;

  logic [LANE_W-1:0] divisorMag;
  logic [LANE_W-1:0] partRem;
  logic [DIVD_W-1:0] quoShift;
  logic              negRes;
  logic              divZero;

  logic              aNeg, bNeg;
  logic [LANE_W-1:0] aMag, bMag;
  logic [LANE_W:0]   trial;
  logic              fits;
  logic [LANE_W-1:0] remNext;
  logic [DIVD_W-1:0] quoNext;
  logic [LANE_W-1:0] magLow;
  logic [LANE_W-1:0] finalVal;

  // Operand magnitudes for the load cycle
  always_comb begin
    aNeg = dpCtrl.signedOp && opA[LANE_W-1];
    bNeg = dpCtrl.signedOp && opB[LANE_W-1];
    aMag = aNeg ? (~opA + 1'b1) : opA;
    bMag = bNeg ? (~opB + 1'b1) : opB;
  end

  // One restoring-division step
  always_comb begin
    trial   = {partRem, quoShift[DIVD_W-1]};
    fits    = trial[LANE_W] || (trial[LANE_W-1:0] >= divisorMag);
    remNext = fits ? (trial[LANE_W-1:0] - divisorMag) : trial[LANE_W-1:0];
    quoNext = {quoShift[DIVD_W-2:0], fits};
  end

  // Sign and zero-divisor fixup on the final quotient
  always_comb begin
    magLow = quoNext[LANE_W-1:0];
    if (divZero) begin
      finalVal = '0;
    end else if (negRes) begin
      finalVal = ~magLow + 1'b1;
    end else begin
      finalVal = magLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisorMag <= '0;
      partRem    <= '0;
      quoShift   <= '0;
      negRes     <= 1'b0;
      divZero    <= 1'b0;
      res        <= '0;
    end else begin
      if (dpCtrl.load) begin
        divisorMag <= bMag;
        partRem    <= '0;
        quoShift   <= {aMag, {LANE_W{1'b0}}};
        negRes     <= aNeg ^ bNeg;
        divZero    <= (opB == '0);
      end else if (dpCtrl.step) begin
        partRem  <= remNext;
        quoShift <= quoNext;
      end
      if (dpCtrl.finish) begin
        res <= finalVal;
      end
    end
  end

endmodule

// File: rtl/vxdiv_datapath.sv
module vxdiv_datapath
  import vxdiv_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrl_t                 dpCtrl,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  output logic [LANES*LANE_W-1:0] result
);

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    vxdiv_lane #(.LANE_W(LANE_W)) u_lane (
      .clk    (clk),
      .rstN   (rstN),
      .dpCtrl (dpCtrl),
      .opA    (srcA[gi*LANE_W +: LANE_W]),
      .opB    (srcB[gi*LANE_W +: LANE_W]),
      .res    (result[gi*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/vxdiv_unit.sv
module vxdiv_unit
  import vxdiv_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [5:0]              primOp,
  input  logic [10:0]             extOp,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  output logic                    busy,
  output logic                    done,
  output logic                    illegal,
  output logic [LANES*LANE_W-1:0] result
);

  localparam int ITER = 2 * LANE_W;

  dpCtrl_t dpCtrl;

  vxdiv_ctrl #(.ITER(ITER)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .primOp  (primOp),
    .extOp   (extOp),
    .dpCtrl  (dpCtrl),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
  );

  vxdiv_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dpCtrl (dpCtrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result)
  );

endmodule

// File: rtl/vxdiv_chk.sv
module vxdiv_chk
  import vxdiv_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic [5:0]              primOp,
  input logic [10:0]             extOp,
  input logic                    busy,
  input logic                    done,
  input logic                    illegal,
  input logic [LANES*LANE_W-1:0] result
);

  localparam int ITER  = 2 * LANE_W;
  localparam int RCNT_W = $clog2(ITER) + 1;

  logic legalOp;
  assign legalOp = (primOp == PRIMARY_OP) &&
                   ((extOp == XOP_SIGNED) || (extOp == XOP_UNSIGNED));

  // Cycles since the accepting edge
  logic [RCNT_W-1:0] runCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!busy && start && legalOp) begin
      runCnt <= '0;
    end else if (busy) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && legalOp) |=> busy);

  p_reject_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !legalOp) |=> (illegal && !busy));

  p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!busy && !done));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == RCNT_W'(ITER)));

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (!illegal && (busy || done)));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

endmodule

bind vxdiv_unit vxdiv_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .primOp  (primOp),
  .extOp   (extOp),
  .busy    (busy),
  .done    (done),
  .illegal (illegal),
  .result  (result)
);

// File: tb/vxdiv_unit_tb.sv
`timescale 1ns/1ps
module vxdiv_unit_tb;

  localparam int NVEC = 5;
  // {signed, srcA, srcB}
  localparam logic [256:0] VECS [0:NVEC-1] = '{
    {1'b0, 128'h00000001_00000003_7FFFFFFF_00000000, 128'h00000002_00000007_80000000_00000005},
    {1'b0, 128'hFFFFFFFE_12345678_00000010_80000000, 128'hFFFFFFFF_9ABCDEF0_00000003_00000001},
    {1'b1, 128'hFFFFFFFF_00000005_80000000_7FFFFFFF, 128'h00000002_FFFFFFF9_FFFFFFFF_80000000},
    {1'b1, 128'h00000003_FFFFFFFD_00001000_C0000000, 128'h00000010_00000010_FFFF0000_00000007},
    {1'b0, 128'h0000ABCD_00000001_FFFFFFFF_00000000, 128'h00010000_00000001_FFFFFFFF_FFFFFFFF}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [5:0]   primOp = '0;
  logic [10:0]  extOp = '0;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic         busy, done, illegal;
  logic [127:0] result;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  vxdiv_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .primOp(primOp), .extOp(extOp),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done), .illegal(illegal),
    .result(result)
  );

  function automatic logic [31:0] refLane(input logic sgn, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] q;
    logic [31:0] aM, bM, lo;
    if (b == 32'h0) return 32'h0;
    if (!sgn) begin
      q = {a, 32'h0} / {32'h0, b};
      return q[31:0];
    end
    aM = a[31] ? (~a + 32'h1) : a;
    bM = b[31] ? (~b + 32'h1) : b;
    q  = {aM, 32'h0} / {32'h0, bM};
    lo = q[31:0];
    return (a[31] ^ b[31]) ? (~lo + 32'h1) : lo;
  endfunction

  function automatic logic [127:0] refVec(input logic sgn, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[i*32 +: 32] = refLane(sgn, a[i*32 +: 32], b[i*32 +: 32]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [5:0] p, input logic [10:0] x,
                            input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    primOp = p; extOp = x; srcA = a; srcB = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Counts rising edges after the accepting edge until done is seen
  task automatic waitDone(output int lat);
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
  endtask

  function automatic logic [10:0] xop(input logic sgn);
    return sgn ? 11'b01110001011 : 11'b01010001011;
  endfunction

  task automatic runOp(input string req, input logic sgn, input logic [127:0] a, input logic [127:0] b);
    int lat;
    pulseStart(6'b000100, xop(sgn), a, b);
    chk({req, " busy after accept (R1)"}, {127'b0, busy}, 128'd1);
    waitDone(lat);
    chk({req, " latency (R8)"}, 128'(lat), 128'd64);
    chk({req, " busy low at done (R8)"}, {127'b0, busy}, 128'd0);
    chk(req, result, refVec(sgn, a, b));
    @(posedge clk); @(negedge clk);
    chk({req, " done single cycle (R8)"}, {127'b0, done}, 128'd0);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [127:0] held;
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 reset flags", {125'b0, busy, done, illegal}, 128'd0);
    chk("R10 reset result", result, 128'h0);
    rstN = 1'b1;

    // Table of vectors: R3 unsigned, R4 signed, R5 per-lane
    for (int v = 0; v < NVEC; v++) begin
      runOp(VECS[v][256] ? "R4 R5 signed vector" : "R3 R5 unsigned vector",
            VECS[v][256], VECS[v][255:128], VECS[v][127:0]);
    end

    // R6 zero divisor lanes, signed and unsigned
    runOp("R6 zero divisor signed", 1'b1,
          128'h11111111_80000000_00000007_00000001, 128'h00000000_00000003_00000000_FFFFFFFF);
    runOp("R6 zero divisor unsigned", 1'b0,
          128'h11111111_80000000_00000007_00000001, 128'h00000000_00000003_00000000_FFFFFFFF);
    chk("R6 zero lane value", {96'h0, result[127:96]}, 128'h0);

    // R7 most negative by minus one
    runOp("R7 min by minus one", 1'b1,
          {4{32'h80000000}}, {4{32'hFFFFFFFF}});
    chk("R7 min by minus one zero", result, 128'h0);

    // R10 hold after done
    held = result;
    repeat (5) @(negedge clk);
    chk("R10 result hold", result, held);

    // R2 bad extended opcode, then bad primary opcode
    pulseStart(6'b000100, 11'b01110001010, {4{32'h5}}, {4{32'h3}});
    chk("R2 illegal raised", {126'b0, illegal, busy}, 128'd2);
    @(posedge clk); @(negedge clk);
    chk("R2 illegal single cycle", {125'b0, illegal, busy, done}, 128'd0);
    pulseStart(6'b000101, 11'b01010001011, {4{32'h5}}, {4{32'h3}});
    chk("R2 bad primary illegal", {126'b0, illegal, busy}, 128'd2);
    repeat (70) @(negedge clk);
    chk("R2 no done after reject", {126'b0, done, busy}, 128'd0);
    chk("R2 result unchanged", result, held);

    // R9 start while busy ignored
    pulseStart(6'b000100, xop(1'b0), 128'h00000001_00000002_00000003_00000004,
               128'h00000009_00000008_00000007_00000006);
    repeat (10) @(negedge clk);
    srcA = {4{32'h7FFFFFFF}}; srcB = {4{32'h00000002}};
    primOp = 6'b000100; extOp = 11'b00000000000; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R9 no illegal while busy", {127'b0, illegal}, 128'd0);
    pulseStart(6'b000100, xop(1'b1), {4{32'h7FFFFFFF}}, {4{32'h00000002}});
    waitDone(lat);
    chk("R9 latency unchanged", 128'(lat + 13), 128'd64);
    chk("R9 first operation result", result,
        refVec(1'b0, 128'h00000001_00000002_00000003_00000004,
               128'h00000009_00000008_00000007_00000006));
    @(posedge clk); @(negedge clk);
    chk("R9 no second run", {126'b0, busy, done}, 128'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule